// File: doc/BRIEF.md
# Real-Time Clock with Periodic Tick Interrupt

This block keeps wall-clock time as a microseconds counter and a seconds counter, both derived from a reference clock of known frequency. A bus access to the snapshot offset copies both counters into a pair of readable holding registers. Software can then read seconds and microseconds as one consistent pair, even while the live counters keep running.

The block also has a programmable periodic tick. Software writes a rate in Hz. A divider then produces one tick every `CLK_HZ / rate` reference cycles, where `CLK_HZ = CYC_PER_US * US_PER_SEC`. Writing a rate of zero stops the ticks. Each tick adds one to a saturating pending counter, and the interrupt output is high whenever that counter is non-zero. Every access to the acknowledge offset retires exactly one tick. Software that fell behind therefore sees the interrupt stay high until it has acknowledged every tick it missed.

The register port is a plain request strobe with a write flag. It has no back-pressure: every request is taken in the cycle it is presented. Read data comes back one cycle later, marked by a valid pulse.

Top module: `rtc_periodic_timer`

## Requirements
- R1: After reset the interrupt is low and the rate register reads 0. Both snapshot registers read 0. The live seconds counter starts at parameter `INIT_SEC` and the live microseconds counter starts at 0.
- R2: The live microseconds counter advances once every `CYC_PER_US` clock cycles. When it steps from `US_PER_SEC-1` it goes back to 0 and the seconds counter advances by one.
- R3: Any access (read or write) at offset 0x000 copies the live counters, as they stood before that clock edge, into the snapshot registers. Offset 0x010 returns the snapshot seconds and offset 0x020 returns the snapshot microseconds. Both values stay the same until the next snapshot.
- R4: A read request returns its data on `bus_rdata` with `bus_rvalid` high in the following cycle. A write sets `bus_rvalid` low in that cycle. Offset 0x100 reads back the last rate written.
- R5: While the rate register holds 0, no tick is produced and the pending count does not rise.
- R6: A write to offset 0x100 restarts the divider. With period P = max(1, CLK_HZ / rate), ticks fall on the clock edges P, 2P, 3P, ... after the write edge.
- R7: Each tick adds one to the pending count. `irq_o` is high exactly when the pending count is non-zero.
- R8: Any access (read or write) at offset 0x110 removes one pending tick. An access when nothing is pending has no effect.
- R9: The pending count saturates at 2^PEND_W-1 rather than wrapping.
- R10: When a tick and an acknowledge fall on the same edge, the pending count is unchanged.
- R11: Writing a new rate, including 0, keeps the pending ticks already counted.
- R12: An access to any other offset reads 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | High in the cycle the read data is valid |
| irq_o | output | 1 | High while any tick is pending |

## Verification
Snapshot values are expected from the edge that samples the snapshot request. After k edges since reset, that edge latches k / CYC_PER_US elapsed microseconds. Read data is sampled on the falling edge after the request's rising edge. A tick counted from a rate write on edge w first shows on `irq_o` after edge w+P. An acknowledge shows right after its own edge. The bench counts rising edges itself and only drives or samples on falling edges, so each check lands in the cycle these latencies give. The same-edge tick and acknowledge case is placed on edge w+P by that count.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int REG_AW = 12;
  localparam int REG_DW = 32;

  localparam logic [REG_AW-1:0] OFS_SNAP  = 12'h000;
  localparam logic [REG_AW-1:0] OFS_SEC   = 12'h010;
  localparam logic [REG_AW-1:0] OFS_USEC  = 12'h020;
  localparam logic [REG_AW-1:0] OFS_RATE  = 12'h100;
  localparam logic [REG_AW-1:0] OFS_ACK   = 12'h110;
endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
  parameter int          CYC_PER_US = 4,
  parameter int          US_PER_SEC = 1000000,
  parameter logic [31:0] INIT_SEC   = 32'd0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [$clog2(US_PER_SEC)-1:0] us_o,
  output logic [31:0]                   sec_o,
  output logic                          us_stb_o
);
  localparam int US_W  = $clog2(US_PER_SEC);
  localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [US_W-1:0] US_LAST = US_W'(US_PER_SEC - 1);

  logic us_stb;

  generate
    if (CYC_PER_US > 1) begin : g_prescale
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYC_PER_US - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (!rst_n)               pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                      pre_q <= pre_q + 1'b1;
      end
      assign us_stb = (pre_q == PRE_LAST);
    end else begin : g_direct
      assign us_stb = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      us_o  <= '0;
      sec_o <= INIT_SEC;
    end else if (us_stb) begin
      if (us_o == US_LAST) begin
        us_o  <= '0;
        sec_o <= sec_o + 32'd1;
      end else begin
        us_o  <= us_o + 1'b1;
      end
    end
  end

  assign us_stb_o = us_stb;
endmodule

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int DIV_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] period_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] period_q;
  logic [DIV_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == period_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= DIV_W'(1);
      cnt_q    <= '0;
    end else if (load_i) begin
      period_q <= period_i;
      cnt_q    <= '0;
    end else if (run_i) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = run_i && at_end && !load_i;
endmodule

// File: rtl/rtc_pending_ctr.sv
module rtc_pending_ctr #(
  parameter int PEND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ack_i,
  output logic [PEND_W-1:0] count_o
);
  localparam logic [PEND_W-1:0] FULL = {PEND_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_o <= '0;
    end else begin
      unique case ({tick_i, ack_i})
        2'b10:   if (count_o != FULL) count_o <= count_o + 1'b1;
        2'b01:   if (count_o != '0)   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/rtc_periodic_timer.sv
module rtc_periodic_timer
  import rtc_pkg::*;
#(
  parameter int          CYC_PER_US = 4,
  parameter int          US_PER_SEC = 1000000,
  parameter int          PEND_W     = 8,
  parameter logic [31:0] INIT_SEC   = 32'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [REG_DW-1:0] bus_wdata,
  output logic [REG_DW-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_o
);
  localparam int CLK_HZ = CYC_PER_US * US_PER_SEC;
  localparam int DIV_W  = $clog2(CLK_HZ + 1);
  localparam int US_W   = $clog2(US_PER_SEC);

  logic [US_W-1:0]   us_w;
  logic [31:0]       sec_w;
  logic              us_stb_w;
  logic [31:0]       snap_sec_q;
  logic [US_W-1:0]   snap_us_q;
  logic [REG_DW-1:0] freq_q;
  logic              tick_w;
  logic              ack_w;
  logic [PEND_W-1:0] pend_w;
  logic              sel_snap, sel_rate_wr;
  logic [31:0]       divisor, quot;
  logic [DIV_W-1:0]  new_period;

  rtc_timebase #(
    .CYC_PER_US(CYC_PER_US), .US_PER_SEC(US_PER_SEC), .INIT_SEC(INIT_SEC)
  ) u_timebase (
    .clk(clk), .rst_n(rst_n), .us_o(us_w), .sec_o(sec_w), .us_stb_o(us_stb_w)
  );

  assign sel_snap    = bus_req && (bus_addr == OFS_SNAP);
  assign sel_rate_wr = bus_req && bus_we && (bus_addr == OFS_RATE);
  assign ack_w       = bus_req && (bus_addr == OFS_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_sec_q <= '0;
      snap_us_q  <= '0;
    end else if (sel_snap) begin
      snap_sec_q <= sec_w;
      snap_us_q  <= us_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           freq_q <= '0;
    else if (sel_rate_wr) freq_q <= bus_wdata;
  end

  assign divisor    = (bus_wdata == '0) ? 32'd1 : bus_wdata;
  assign quot       = 32'(CLK_HZ) / divisor;
  assign new_period = (quot == '0) ? DIV_W'(1) : DIV_W'(quot);

  rtc_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load_i(sel_rate_wr), .period_i(new_period),
    .run_i(freq_q != '0), .tick_o(tick_w)
  );

  rtc_pending_ctr #(.PEND_W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_w), .ack_i(ack_w), .count_o(pend_w)
  );

  assign irq_o = (pend_w != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) begin
        unique case (bus_addr)
          OFS_SEC:  bus_rdata <= snap_sec_q;
          OFS_USEC: bus_rdata <= REG_DW'(snap_us_q);
          OFS_RATE: bus_rdata <= freq_q;
          default:  bus_rdata <= '0;
        endcase
      end else begin
        bus_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/rtc_timer_chk.sv
module rtc_timer_chk #(
  parameter int US_PER_SEC = 1000000,
  parameter int PEND_W     = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick,
  input logic                          ack,
  input logic [PEND_W-1:0]             pend,
  input logic [$clog2(US_PER_SEC)-1:0] us,
  input logic [31:0]                   sec,
  input logic                          us_stb,
  input logic [31:0]                   freq,
  input logic                          irq
);
  localparam int US_W = $clog2(US_PER_SEC);
  localparam logic [US_W-1:0]   US_LAST = US_W'(US_PER_SEC - 1);
  localparam logic [PEND_W-1:0] FULL    = {PEND_W{1'b1}};

  a_r2_us_range: assert property (@(posedge clk) disable iff (!rst_n)
    us <= US_LAST);
  a_r2_sec_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (us_stb && us == US_LAST) |=> (us == '0 && sec == $past(sec) + 32'd1));
  a_r2_us_step: assert property (@(posedge clk) disable iff (!rst_n)
    (us_stb && us != US_LAST) |=> (us == $past(us) + 1'b1 && $stable(sec)));
  a_r5_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (freq == '0) |-> !tick);
  a_r7_tick_adds: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ack && pend != FULL) |=> pend == $past(pend) + 1'b1);
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ack) |=> irq);
  a_r8_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !tick && pend != '0) |=> pend == $past(pend) - 1'b1);
  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ack && pend == FULL) |=> pend == FULL);
  a_r10_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ack) |=> $stable(pend));
endmodule

bind rtc_periodic_timer rtc_timer_chk #(
  .US_PER_SEC(US_PER_SEC), .PEND_W(PEND_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick_w), .ack(ack_w), .pend(pend_w),
  .us(us_w), .sec(sec_w), .us_stb(us_stb_w), .freq(freq_q), .irq(irq_o)
);

// File: tb/rtc_periodic_timer_tb.sv
module rtc_periodic_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 2;
  localparam int USPS       = 50;
  localparam int PW         = 3;
  localparam int HZ         = CYC * USPS;
  localparam int SAT        = (1 << PW) - 1;
  localparam logic [31:0] SEC0 = 32'd1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

  rtc_periodic_timer #(.CYC_PER_US(CYC), .US_PER_SEC(USPS), .PEND_W(PW),
                       .INIT_SEC(SEC0)) u_dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one access; returns the edge that samples it and the data/valid seen after
  task automatic xfer(input bit we, input logic [11:0] a, input logic [31:0] d,
                      output logic [31:0] q, output bit v, output int e);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    e = cyc + 1;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
    q = bus_rdata; v = bus_rvalid;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, output int e);
    logic [31:0] q; bit v;
    xfer(1'b1, a, d, q, v, e);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] q);
    bit v; int e;
    xfer(1'b0, a, 32'd0, q, v, e);
    chk("R4 rvalid", v, 1);
  endtask

  task automatic wait_to(input int edge_no);
    while (cyc < edge_no) @(negedge clk);
  endtask

  function automatic int period_of(input int f);
    return (HZ / f == 0) ? 1 : HZ / f;
  endfunction

  function automatic int ticks_between(input int w, input int s, input int p);
    int k = (s - 1 - w) / p;
    return (k > SAT) ? SAT : k;
  endfunction

  // acknowledge n ticks one at a time; irq must stay high until the last
  task automatic drain(input int n, input string req);
    int e;
    for (int i = 1; i <= n; i++) begin
      wr(12'h110, 32'd0, e);
      chk(req, irq_o, (i < n) ? 1 : 0);
    end
  endtask

  task automatic snap_check(input string req);
    int e; logic [31:0] q; longint tot;
    wr(12'h000, 32'd0, e);
    tot = (e - 1) / CYC;
    rd(12'h010, q); chk({req, " seconds"}, q, SEC0 + tot / USPS);
    rd(12'h020, q); chk({req, " micros"}, q, tot % USPS);
  endtask

  initial begin
    int e, w, s, f, p; logic [31:0] q; logic [31:0] held;
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 irq at reset", irq_o, 0);
    rd(12'h100, q); chk("R1 rate at reset", q, 0);
    rd(12'h010, q); chk("R1 snapshot sec at reset", q, 0);
    rd(12'h020, q); chk("R1 snapshot us at reset", q, 0);
    snap_check("R1 initial seconds");

    // R2/R3: snapshots at random times, spanning several seconds
    for (int i = 0; i < 8; i++) begin
      repeat ($urandom_range(0, 140)) @(negedge clk);
      snap_check("R2 R3 snapshot");
    end
    rd(12'h010, held);
    repeat (130) @(negedge clk);
    rd(12'h010, q); chk("R3 snapshot held", q, held);

    // R5: rate 0 produces nothing
    repeat (60) @(negedge clk);
    chk("R5 no tick while off", irq_o, 0);

    // R12: unmapped offset
    rd(12'h030, q); chk("R12 unmapped reads 0", q, 0);
    rd(12'h100, q); chk("R12 rate untouched", q, 0);

    // R6/R7/R10: period 10, ack on the first tick edge cancels it
    wr(12'h100, 32'd10, w);
    rd(12'h100, q); chk("R4 rate readback", q, 10);
    wait_to(w + 9);
    chk("R6 no tick before period", irq_o, 0);
    wr(12'h110, 32'd0, e);
    chk("R10 tick+ack same edge", irq_o, 0);
    wait_to(w + 19);
    chk("R6 second period not yet", irq_o, 0);
    @(negedge clk);
    chk("R7 tick raises irq", irq_o, 1);

    // R11: new rate keeps pending, restarts divider (period 5)
    wr(12'h100, 32'd20, w);
    chk("R11 pending kept on rate write", irq_o, 1);
    wait_to(w + 12);
    wr(12'h100, 32'd0, s);
    drain(1 + ticks_between(w, s, 5), "R8 R11 drain after rate change");

    // R9: saturation with period 4
    wr(12'h100, 32'd25, w);
    repeat (60) @(negedge clk);
    wr(12'h100, 32'd0, s);
    drain(SAT, "R9 saturated count");
    wr(12'h110, 32'd0, e);
    chk("R8 ack when empty", irq_o, 0);
    rd(12'h110, q);
    chk("R8 read ack when empty", irq_o, 0);

    // R6 clamp: rate above CLK_HZ ticks every cycle
    wr(12'h100, 32'd200, w);
    wait_to(w + 2);
    wr(12'h100, 32'd0, s);
    drain(ticks_between(w, s, 1), "R6 clamp period 1");

    // R6/R7/R8 random rounds
    for (int i = 0; i < 6; i++) begin
      f = $urandom_range(4, 50);
      p = period_of(f);
      wr(12'h100, f, w);
      repeat ($urandom_range(3, 40)) @(negedge clk);
      wr(12'h100, 32'd0, s);
      if (ticks_between(w, s, p) == 0) chk("R6 no tick yet", irq_o, 0);
      else drain(ticks_between(w, s, p), "R6 R7 R8 random count");
    end

    // R8 read access also acknowledges
    wr(12'h100, 32'd50, w);
    wait_to(w + 5);
    wr(12'h100, 32'd0, s);
    chk("R7 two ticks pending", irq_o, 1);
    rd(12'h110, q); chk("R8 read ack one left", irq_o, 1);
    rd(12'h110, q); chk("R8 read ack none left", irq_o, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule